// File: doc/BRIEF.md
# Dataflow Operand Matching Table

This block sits between the operand receive stage and the instruction scheduler of a dataflow processing element. Each arriving token names one input port of a resident instruction and carries a full tag of thread identifier, wave number and instruction identifier, together with a data value. The block hashes the tag to pick a slot in a token store. It records which ports of that instance have been filled, and holds the partial operand values there.

When the last missing operand of an instance arrives, the block presents a fire request on the cycle after. The request carries the complete tag and every operand value side by side, and the slot is freed. Each instruction's operand count, from one to three, lives in a small table that is written through a configuration port.

A token whose slot is held by a different tag is not allowed to overwrite it. The block raises a miss flag and withholds ready until the slot drains. A token that repeats an already filled port, or names a port beyond the instruction's operand count, is dropped and reported as a protocol error.

Top module: `tag_match_table`

## Requirements
- R1: After reset, fire_valid and proto_err are 0, miss is 0, tok_ready is 1, every store slot is empty, and every instruction's operand count is 1.
- R2: A cycle with cfg_we high sets the operand count of instruction cfg_iid to cfg_nops, and that count applies to tokens presented from the next cycle on. Legal counts are 1, 2 and 3.
- R3: The slot index has 7 bits h[6:0] and starts at zero. Instruction identifier bit i is XORed into h[(i+1) mod 7], wave bit i into h[i mod 7], and thread bit i into h[(i+3) mod 7].
- R4: A token accepted for a single-operand instruction produces fire_valid on the following cycle. Its value appears in slot 0 of fire_data (bits 15:0), and slots 1 and 2 are zero.
- R5: For a multi-operand instruction, fire_valid rises on the cycle after the last missing port is accepted, whatever the arrival order. The value of port p appears in fire_data[16p+15:16p], and slots at or above the operand count read zero.
- R6: On a fire, fire_thread, fire_wave and fire_iid equal the tag of the completing token. Instances that differ only in wave number are matched separately.
- R7: A valid token whose slot is occupied by a different full tag drives miss high and tok_ready low in the same cycle. It changes nothing, and it is accepted once that slot has fired.
- R8: A token for a port already present in its slot is dropped. proto_err pulses on the next cycle, no fire occurs, and the first stored value is kept.
- R9: A token whose port number is not below its instruction's operand count is dropped, and proto_err pulses on the next cycle.
- R10: A slot is released when it fires, so a later token with the same tag starts a fresh operand set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Operand count write strobe |
| cfg_iid | input | 6 | Instruction whose count is written |
| cfg_nops | input | 2 | Operand count to write (1 to 3) |
| tok_valid | input | 1 | Token present |
| tok_thread | input | 4 | Token thread identifier |
| tok_wave | input | 8 | Token wave number |
| tok_iid | input | 6 | Token target instruction |
| tok_port | input | 2 | Target input port (0 to 2) |
| tok_data | input | 16 | Operand value |
| tok_ready | output | 1 | Token accepted this cycle |
| miss | output | 1 | Slot held by another tag; token stalled |
| fire_valid | output | 1 | Fire request to the scheduler |
| fire_thread | output | 4 | Thread of the firing instance |
| fire_wave | output | 8 | Wave of the firing instance |
| fire_iid | output | 6 | Instruction of the firing instance |
| fire_data | output | 48 | Operand values, port p at bits 16p+15:16p |
| proto_err | output | 1 | Pulse: token dropped as duplicate or out of range |

## Verification
A corrupted presence bit shows as a fire that comes one token too early or never comes, visible on the cycle after the completing token. A stale tag or valid flag shows up at once as a spurious miss on an unrelated token, or as a missing miss on the colliding pair. Mixed-up operand slots show as swapped fields in fire_data on the fire cycle. A slot that is not released turns the next instance with the same tag into an early fire or a protocol error.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef enum logic [1:0] {
    LK_EMPTY    = 2'd0,
    LK_HIT      = 2'd1,
    LK_CONFLICT = 2'd2
  } lookup_e;
endpackage

// File: rtl/tmt_opcount.sv
module tmt_opcount #(
  parameter int IW    = 6,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_iid,
  input  logic [CNT_W-1:0] cfg_nops,
  input  logic [IW-1:0]    rd_iid,
  output logic [CNT_W-1:0] rd_nops
);
  localparam int NINSTR = 1 << IW;

  logic [CNT_W-1:0] cnt_q [NINSTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NINSTR; i++) cnt_q[i] <= CNT_W'(1);
    end else if (cfg_we) begin
      cnt_q[cfg_iid] <= cfg_nops;
    end
  end

  assign rd_nops = cnt_q[rd_iid];

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cnt_q[$past(cfg_iid)] == $past(cfg_nops));
endmodule

// File: rtl/tmt_store.sv
module tmt_store
  import tmt_pkg::*;
#(
  parameter int TW     = 4,
  parameter int WW     = 8,
  parameter int IW     = 6,
  parameter int DW     = 16,
  parameter int MAXOPS = 3,
  parameter int DEPTH  = 128,
  localparam int PORT_W = $clog2(MAXOPS),
  localparam int CNT_W  = $clog2(MAXOPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tok_valid,
  input  logic [TW-1:0]        tok_thread,
  input  logic [WW-1:0]        tok_wave,
  input  logic [IW-1:0]        tok_iid,
  input  logic [PORT_W-1:0]    tok_port,
  input  logic [DW-1:0]        tok_data,
  input  logic [CNT_W-1:0]     nops,
  output logic                 miss,
  output logic                 cmp_fire,
  output logic                 cmp_err,
  output logic [MAXOPS*DW-1:0] cmp_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = TW + WW + IW;

  function automatic logic [IDX_W-1:0] slot_of(logic [TW-1:0] t, logic [WW-1:0] w,
                                               logic [IW-1:0] n);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < IW; i++) h[(i + 1) % IDX_W] ^= n[i];
    for (int i = 0; i < WW; i++) h[i % IDX_W] ^= w[i];
    for (int i = 0; i < TW; i++) h[(i + 3) % IDX_W] ^= t[i];
    return h;
  endfunction

  logic              vld_q  [DEPTH];
  logic [MAXOPS-1:0] pres_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DW-1:0]     dat_q  [DEPTH][MAXOPS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  lookup_e           lk;
  logic [MAXOPS-1:0] sel, need, base, newpres;
  logic              accept, port_bad, dup, good, complete, write_en;

  always_comb begin
    idx = slot_of(tok_thread, tok_wave, tok_iid);
    tag = {tok_thread, tok_wave, tok_iid};
    if (!vld_q[idx])              lk = LK_EMPTY;
    else if (tag_q[idx] == tag)   lk = LK_HIT;
    else                          lk = LK_CONFLICT;
    for (int p = 0; p < MAXOPS; p++) begin
      sel[p]  = (tok_port == PORT_W'(p));
      need[p] = (CNT_W'(p) < nops);
    end
    base     = (lk == LK_HIT) ? pres_q[idx] : '0;
    newpres  = base | sel;
    accept   = tok_valid && (lk != LK_CONFLICT);
    port_bad = ({{(CNT_W + 1 - PORT_W){1'b0}}, tok_port} >= {1'b0, nops});
    dup      = |(sel & base);
    cmp_err  = accept && (port_bad || dup);
    good     = accept && !cmp_err;
    complete = good && ((newpres & need) == need);
    write_en = good && !complete;
    cmp_fire = complete;
    miss     = tok_valid && (lk == LK_CONFLICT);
    for (int p = 0; p < MAXOPS; p++) begin
      if (sel[p])       cmp_data[p*DW +: DW] = tok_data;
      else if (base[p]) cmp_data[p*DW +: DW] = dat_q[idx][p];
      else              cmp_data[p*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i]  <= 1'b0;
        pres_q[i] <= '0;
      end
    end else if (write_en) begin
      vld_q[idx]  <= 1'b1;
      pres_q[idx] <= newpres;
    end else if (complete) begin
      vld_q[idx]  <= 1'b0;
      pres_q[idx] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (write_en) begin
      tag_q[idx] <= tag;
      for (int p = 0; p < MAXOPS; p++)
        if (sel[p]) dat_q[idx][p] <= tok_data;
    end
  end

  // R10
  release_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !vld_q[$past(idx)]);
  // R7
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> vld_q[$past(idx)] && tag_q[$past(idx)] == $past(tag_q[idx]));
  // R8
  dup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_err && lk == LK_HIT) |=> pres_q[$past(idx)] == $past(pres_q[idx]));
endmodule

// File: rtl/tmt_fire.sv
module tmt_fire #(
  parameter int TAG_W = 18,
  parameter int FD_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_fire,
  input  logic             cmp_err,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [FD_W-1:0]  cmp_data,
  output logic             fire_valid,
  output logic [TAG_W-1:0] fire_tag,
  output logic [FD_W-1:0]  fire_data,
  output logic             proto_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_valid <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      fire_valid <= cmp_fire;
      proto_err  <= cmp_err;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_fire) begin
      fire_tag  <= cmp_tag;
      fire_data <= cmp_data;
    end
  end

  // R8
  err_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !fire_valid);
endmodule

// File: rtl/tag_match_table.sv
module tag_match_table #(
  parameter int TW     = 4,
  parameter int WW     = 8,
  parameter int IW     = 6,
  parameter int DW     = 16,
  parameter int MAXOPS = 3,
  parameter int DEPTH  = 128,
  localparam int PORT_W = $clog2(MAXOPS),
  localparam int CNT_W  = $clog2(MAXOPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_iid,
  input  logic [CNT_W-1:0]     cfg_nops,
  input  logic                 tok_valid,
  input  logic [TW-1:0]        tok_thread,
  input  logic [WW-1:0]        tok_wave,
  input  logic [IW-1:0]        tok_iid,
  input  logic [PORT_W-1:0]    tok_port,
  input  logic [DW-1:0]        tok_data,
  output logic                 tok_ready,
  output logic                 miss,
  output logic                 fire_valid,
  output logic [TW-1:0]        fire_thread,
  output logic [WW-1:0]        fire_wave,
  output logic [IW-1:0]        fire_iid,
  output logic [MAXOPS*DW-1:0] fire_data,
  output logic                 proto_err
);
  localparam int TAG_W = TW + WW + IW;

  logic [CNT_W-1:0]     nops;
  logic                 cmp_fire, cmp_err;
  logic [MAXOPS*DW-1:0] cmp_data;
  logic [TAG_W-1:0]     fire_tag;

  tmt_opcount #(.IW(IW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_iid(cfg_iid),
    .cfg_nops(cfg_nops), .rd_iid(tok_iid), .rd_nops(nops)
  );

  tmt_store #(.TW(TW), .WW(WW), .IW(IW), .DW(DW), .MAXOPS(MAXOPS),
              .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_thread(tok_thread),
    .tok_wave(tok_wave), .tok_iid(tok_iid), .tok_port(tok_port),
    .tok_data(tok_data), .nops(nops), .miss(miss), .cmp_fire(cmp_fire),
    .cmp_err(cmp_err), .cmp_data(cmp_data)
  );

  tmt_fire #(.TAG_W(TAG_W), .FD_W(MAXOPS*DW)) u_fire (
    .clk(clk), .rst_n(rst_n), .cmp_fire(cmp_fire), .cmp_err(cmp_err),
    .cmp_tag({tok_thread, tok_wave, tok_iid}), .cmp_data(cmp_data),
    .fire_valid(fire_valid), .fire_tag(fire_tag), .fire_data(fire_data),
    .proto_err(proto_err)
  );

  assign tok_ready = !miss;
  assign {fire_thread, fire_wave, fire_iid} = fire_tag;

  // R7
  stall_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> !fire_valid);
  // R7
  miss_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> tok_valid);
endmodule

// File: tb/sim_tag_match_table.sv
module sim_tag_match_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_iid;
  logic [1:0]  cfg_nops;
  logic        tok_valid;
  logic [3:0]  tok_thread;
  logic [7:0]  tok_wave;
  logic [5:0]  tok_iid;
  logic [1:0]  tok_port;
  logic [15:0] tok_data;
  logic        tok_ready, miss, fire_valid, proto_err;
  logic [3:0]  fire_thread;
  logic [7:0]  fire_wave;
  logic [5:0]  fire_iid;
  logic [47:0] fire_data;

  int errors = 0;
  int total  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tag_match_table u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_iid(cfg_iid),
    .cfg_nops(cfg_nops), .tok_valid(tok_valid), .tok_thread(tok_thread),
    .tok_wave(tok_wave), .tok_iid(tok_iid), .tok_port(tok_port),
    .tok_data(tok_data), .tok_ready(tok_ready), .miss(miss),
    .fire_valid(fire_valid), .fire_thread(fire_thread), .fire_wave(fire_wave),
    .fire_iid(fire_iid), .fire_data(fire_data), .proto_err(proto_err)
  );

  // {thread4, wave8, iid6, port2, data16, fire1, slot0 16, slot1 16, slot2 16}
  localparam logic [84:0] VEC [8] = '{
    {4'd1, 8'd2, 6'd9, 2'd0, 16'h1111, 1'b1, 16'h1111, 16'h0000, 16'h0000},
    {4'd1, 8'd2, 6'd5, 2'd2, 16'h00A2, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    {4'd1, 8'd2, 6'd5, 2'd0, 16'h00A0, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    {4'd1, 8'd2, 6'd5, 2'd1, 16'h00A1, 1'b1, 16'h00A0, 16'h00A1, 16'h00A2},
    {4'd1, 8'd2, 6'd7, 2'd1, 16'h00B1, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    {4'd1, 8'd3, 6'd7, 2'd0, 16'h00C0, 1'b0, 16'h0000, 16'h0000, 16'h0000},
    {4'd1, 8'd2, 6'd7, 2'd0, 16'h00B0, 1'b1, 16'h00B0, 16'h00B1, 16'h0000},
    {4'd1, 8'd3, 6'd7, 2'd1, 16'h00C1, 1'b1, 16'h00C0, 16'h00C1, 16'h0000}
  };

  function automatic logic [6:0] model_slot(logic [3:0] t, logic [7:0] w, logic [5:0] n);
    logic [6:0] h = '0;
    for (int i = 0; i < 6; i++) h[(i + 1) % 7] ^= n[i];
    for (int i = 0; i < 8; i++) h[i % 7] ^= w[i];
    for (int i = 0; i < 4; i++) h[(i + 3) % 7] ^= t[i];
    return h;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [5:0] i, input logic [1:0] n);
    cfg_we = 1'b1; cfg_iid = i; cfg_nops = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(input logic [3:0] t, input logic [7:0] w, input logic [5:0] i,
                     input logic [1:0] p, input logic [15:0] d);
    tok_valid = 1'b1; tok_thread = t; tok_wave = w; tok_iid = i;
    tok_port = p; tok_data = d;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_iid = '0; cfg_nops = '0;
    tok_valid = 1'b0; tok_thread = '0; tok_wave = '0; tok_iid = '0;
    tok_port = '0; tok_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fire_valid", 64'(fire_valid), 64'd0);
    chk("R1 proto_err", 64'(proto_err), 64'd0);
    chk("R1 miss", 64'(miss), 64'd0);
    chk("R1 tok_ready", 64'(tok_ready), 64'd1);

    // R2 operand counts
    cfg(6'd5, 2'd3);
    cfg(6'd7, 2'd2);

    // Vector walk: R4 single operand, R5 any order, R6 tag separation
    for (int k = 0; k < 8; k++) begin
      logic [84:0] v;
      v = VEC[k];
      put(v[84:81], v[80:73], v[72:67], v[66:65], v[64:49]);
      chk($sformatf("R5 fire_valid vec%0d", k), 64'(fire_valid), 64'(v[48]));
      if (v[48]) begin
        chk($sformatf("R4 fire_data vec%0d", k), 64'(fire_data),
            64'({v[15:0], v[31:16], v[47:32]}));
        chk($sformatf("R6 fire tag vec%0d", k),
            64'({fire_thread, fire_wave, fire_iid}), 64'(v[84:67]));
      end
    end

    // R3 / R7: waves 0x00 and 0x81 share a slot by the hash rule
    chk("R3 model collision", 64'(model_slot(4'd0, 8'h00, 6'd7) == model_slot(4'd0, 8'h81, 6'd7)), 64'd1);
    put(4'd0, 8'h00, 6'd7, 2'd0, 16'h0010);
    chk("R7 first stored no fire", 64'(fire_valid), 64'd0);
    tok_valid = 1'b1; tok_thread = 4'd0; tok_wave = 8'h81; tok_iid = 6'd7;
    tok_port = 2'd0; tok_data = 16'h0020;
    #1;
    chk("R3 R7 miss on collision", 64'(miss), 64'd1);
    chk("R7 ready low", 64'(tok_ready), 64'd0);
    @(negedge clk);
    chk("R7 stalled no fire", 64'(fire_valid), 64'd0);
    chk("R7 miss held", 64'(miss), 64'd1);
    tok_valid = 1'b0;
    put(4'd0, 8'h00, 6'd7, 2'd1, 16'h0011);
    chk("R7 owner fires", 64'(fire_valid), 64'd1);
    chk("R7 owner data intact", 64'(fire_data), 64'h0000_0011_0010);
    tok_valid = 1'b1; tok_thread = 4'd0; tok_wave = 8'h81; tok_iid = 6'd7;
    tok_port = 2'd0; tok_data = 16'h0020;
    #1;
    chk("R7 accepted after drain", 64'(miss), 64'd0);
    @(negedge clk);
    tok_valid = 1'b0;
    put(4'd0, 8'h81, 6'd7, 2'd1, 16'h0021);
    chk("R7 late tag fires", 64'(fire_data), 64'h0000_0021_0020);
    chk("R6 late tag wave", 64'(fire_wave), 64'h81);

    // R8 duplicate port
    put(4'd2, 8'd4, 6'd5, 2'd0, 16'h00D0);
    chk("R8 no err first", 64'(proto_err), 64'd0);
    put(4'd2, 8'd4, 6'd5, 2'd0, 16'h00D9);
    chk("R8 proto_err", 64'(proto_err), 64'd1);
    chk("R8 no fire", 64'(fire_valid), 64'd0);
    put(4'd2, 8'd4, 6'd5, 2'd1, 16'h00D1);
    chk("R8 err is a pulse", 64'(proto_err), 64'd0);
    put(4'd2, 8'd4, 6'd5, 2'd2, 16'h00D2);
    chk("R8 fire", 64'(fire_valid), 64'd1);
    chk("R8 first value kept", 64'(fire_data), 64'h00D2_00D1_00D0);

    // R9 port beyond count (instruction 7 has two operands)
    put(4'd2, 8'd5, 6'd7, 2'd2, 16'h00E2);
    chk("R9 proto_err", 64'(proto_err), 64'd1);
    chk("R9 no fire", 64'(fire_valid), 64'd0);
    put(4'd2, 8'd5, 6'd7, 2'd0, 16'h00E0);
    put(4'd2, 8'd5, 6'd7, 2'd1, 16'h00E1);
    chk("R9 fire unused slot zero", 64'(fire_data), 64'h0000_00E1_00E0);

    // R10 released slot restarts fresh (same tag as vectors 1..3)
    put(4'd1, 8'd2, 6'd5, 2'd1, 16'h0055);
    chk("R10 no early fire", 64'(fire_valid), 64'd0);
    chk("R10 no stale presence", 64'(proto_err), 64'd0);
    put(4'd1, 8'd2, 6'd5, 2'd0, 16'h0050);
    chk("R10 still partial", 64'(fire_valid), 64'd0);
    put(4'd1, 8'd2, 6'd5, 2'd2, 16'h0052);
    chk("R10 fresh set fires", 64'(fire_data), 64'h0052_0055_0050);

    // R2 count change takes effect: instruction 9 now needs two
    cfg(6'd9, 2'd2);
    put(4'd3, 8'd1, 6'd9, 2'd0, 16'h0090);
    chk("R2 new count holds", 64'(fire_valid), 64'd0);
    put(4'd3, 8'd1, 6'd9, 2'd1, 16'h0091);
    chk("R2 fires at new count", 64'(fire_data), 64'h0000_0091_0090);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule